// File: doc/BRIEF.md
# Dual-Mode Word Serializer

The block takes parallel transmit words, captured at the word rate, and sends them out one bit per bit-clock cycle, bit 0 first. The whole block runs on the bit clock. The reference-clock edges reach it as single-cycle enable pulses: `ref_rise` and `ref_fall`. With the default width, a rising pulse comes every ten bit cycles and a falling pulse falls midway between two rising pulses.

Two capture modes are available:

- **Full-word mode:** the whole word is taken on each rising pulse.
- **Split mode:** only the low half of the input bus is used. The half present at the rising pulse becomes the upper half of the word. The half present at the following falling pulse becomes the lower half, and it completes the word.

A captured word moves into the shifter on the next bit cycle, so words presented at the word rate leave without a gap. The mode input only takes effect at the start of a word. A loopback control turns the line driver off and holds the data line low.

Top module: `dual_mode_serializer`

## Requirements
- R1: During reset and after it, until the first word has been loaded, `ser_out` is 0. `ser_oe` is high whenever `loop_en` is low.
- R2: With `mode_sel`=0 on a rising pulse, all WORD_W bits of `par_in` are captured as one word. A falling pulse then has no effect on the output.
- R3: A word captured at the clock edge where a capture pulse is sampled shows its bit 0 on `ser_out` after the next edge. Bit k follows k edges after that.
- R4: Words captured every WORD_W cycles come out back to back. Bit 0 of the next word directly follows the last bit of the previous one.
- R5: With `mode_sel`=1 on a rising pulse, `par_in[HALF-1:0]` at that pulse forms word bits WORD_W-1..HALF. `par_in[HALF-1:0]` at the next falling pulse forms bits HALF-1..0, and the word completes on that falling pulse. In this mode `par_in[WORD_W-1:HALF]` is ignored.
- R6: `mode_sel` is sampled only on rising pulses. A change at any other time does not alter the word in progress.
- R7: While `loop_en` is 1, `ser_oe` is 0 and `ser_out` is 0. Shifting continues underneath.
- R8: Once the last bit of a word has gone out and no new word has been loaded, `ser_out` is 0.
- R9: A falling pulse that follows reset, or that follows a full-word rising pulse, captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_rise | input | 1 | Rising reference-edge pulse |
| ref_fall | input | 1 | Falling reference-edge pulse |
| mode_sel | input | 1 | 0 = full-word capture, 1 = split half-word capture |
| par_in | input | WORD_W | Parallel transmit data |
| loop_en | input | 1 | Loopback: disables the serial driver |
| ser_out | output | 1 | Serial data, bit 0 first |
| ser_oe | output | 1 | Serial driver enable (low models high impedance) |

## Verification
The bench builds the block with WORD_W=10, which gives HALF=5. Every bit position of the full word and of both halves therefore appears on the line, and the half-swap in split mode can be seen directly. The model is a bit queue that is refilled on each load. It lets the bench check gapless words, zero fill after the last bit, mode switches in the middle of a word, and loopback toggled within a word, all on every cycle.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic {
    CAP_FULL  = 1'b0,
    CAP_SPLIT = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/ser_capture.sv
module ser_capture import ser_pkg::*; #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_rise,
  input  logic              ref_fall,
  input  logic              mode_sel,
  input  logic [WORD_W-1:0] par_in,
  output logic [WORD_W-1:0] word_q,
  output logic              word_done
);
  localparam int HALF_W = WORD_W / 2;

  function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                    input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  cap_mode_e         mode_q;
  logic [HALF_W-1:0] upper_q;
  logic              rise_full, rise_split, fall_split;

  assign rise_full  = ref_rise && (mode_sel == CAP_FULL);
  assign rise_split = ref_rise && (mode_sel == CAP_SPLIT);
  assign fall_split = ref_fall && !ref_rise && (mode_q == CAP_SPLIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= CAP_FULL;
      upper_q   <= '0;
      word_q    <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= rise_full || fall_split;
      if (ref_rise) mode_q <= cap_mode_e'(mode_sel);
      if (rise_split) upper_q <= par_in[HALF_W-1:0];
      if (rise_full) word_q <= par_in;
      else if (fall_split) word_q <= join_halves(upper_q, par_in[HALF_W-1:0]);
    end
  end

  assert_split_low_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_split |=> word_q[HALF_W-1:0] == $past(par_in[HALF_W-1:0]));
  assert_mode_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_rise |=> $stable(mode_q));
  assert_done_needs_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fall && !ref_rise && mode_q == CAP_FULL) |=> !word_done);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output logic              bit_out
);
  logic [WORD_W-1:0] shreg, shift_nxt;

  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    if (i == WORD_W - 1) begin : g_top
      assign shift_nxt[i] = 1'b0;
    end else begin : g_mid
      assign shift_nxt[i] = shreg[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else if (load) shreg <= load_word;
    else shreg <= shift_nxt;
  end

  assign bit_out = shreg[0];

  assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bit_out == $past(load_word[0]));
  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> shreg[WORD_W-1] == 1'b0);
endmodule

// File: rtl/ser_line_gate.sv
module ser_line_gate (
  input  logic data_bit,
  input  logic loop_en,
  output logic ser_out,
  output logic ser_oe
);
  assign ser_oe  = !loop_en;
  assign ser_out = data_bit && !loop_en;
endmodule

// File: rtl/dual_mode_serializer.sv
module dual_mode_serializer #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_rise,
  input  logic              ref_fall,
  input  logic              mode_sel,
  input  logic [WORD_W-1:0] par_in,
  input  logic              loop_en,
  output logic              ser_out,
  output logic              ser_oe
);
  logic [WORD_W-1:0] cap_word;
  logic              cap_done;
  logic              shift_bit;
  logic              ever_loaded;

  ser_capture #(.WORD_W(WORD_W)) i_capture (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .ref_fall(ref_fall),
    .mode_sel(mode_sel), .par_in(par_in), .word_q(cap_word), .word_done(cap_done)
  );

  ser_shifter #(.WORD_W(WORD_W)) i_shifter (
    .clk(clk), .rst_n(rst_n), .load(cap_done), .load_word(cap_word), .bit_out(shift_bit)
  );

  ser_line_gate i_gate (
    .data_bit(shift_bit), .loop_en(loop_en), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ever_loaded <= 1'b0;
    else if (cap_done) ever_loaded <= 1'b1;
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ever_loaded |-> !ser_out);
  assert_loop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (!ser_out && !ser_oe));
  assert_full_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !mode_sel) |=> (cap_done && cap_word == $past(par_in)));
endmodule

// File: tb/test_dual_mode_serializer.sv
module test_dual_mode_serializer;
  localparam int W = 10;
  localparam int H = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_rise = 1'b0, ref_fall = 1'b0, mode_sel = 1'b0, loop_en = 1'b0;
  logic [W-1:0] par_in = '0;
  logic ser_out, ser_oe;

  int n_vec = 0, n_bad = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  dual_mode_serializer #(.WORD_W(W)) i_dual_mode_serializer (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .ref_fall(ref_fall),
    .mode_sel(mode_sel), .par_in(par_in), .loop_en(loop_en),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  // behavioural reference: a bit queue refilled by each completed word
  logic bq[$];
  logic m_pend = 1'b0, m_mode = 1'b0, m_bit = 1'b0;
  logic [W-1:0] m_word = '0;
  logic [H-1:0] m_upper = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      bq.delete(); m_pend = 0; m_mode = 0; m_bit = 0; m_word = '0; m_upper = '0;
    end else begin
      if (m_pend) begin
        bq.delete();
        for (int k = 0; k < W; k++) bq.push_back(m_word[k]);
        m_pend = 0;
      end
      m_bit = (bq.size() > 0) ? bq.pop_front() : 1'b0;
      if (ref_rise) begin
        m_mode = mode_sel;
        if (!mode_sel) begin m_pend = 1; m_word = par_in; end
        else m_upper = par_in[H-1:0];
      end else if (ref_fall && m_mode) begin
        m_pend = 1;
        m_word = {m_upper, par_in[H-1:0]};
      end
    end
  end

  task automatic compare();
    logic exp_out, exp_oe;
    exp_oe  = !loop_en;
    exp_out = loop_en ? 1'b0 : m_bit;
    n_vec++;
    if (ser_out !== exp_out || ser_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s: ser_out=%b ser_oe=%b expected ser_out=%b ser_oe=%b",
               cur_tag, ser_out, ser_oe, exp_out, exp_oe);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  // one reference period: rise at slot 0, optional fall at slot H
  task automatic period(input logic m_rise, input logic [W-1:0] d_rise,
                        input logic do_rise, input logic do_fall,
                        input logic [W-1:0] d_fall, input logic m_other,
                        input logic loop_tog, input string tag);
    cur_tag = tag;
    for (int i = 0; i < W; i++) begin
      tick();
      ref_rise = (i == 0) && do_rise;
      ref_fall = (i == H) && do_fall;
      mode_sel = (i == 0) ? m_rise : m_other;
      par_in   = (i == 0) ? d_rise : (i == H) ? d_fall : W'($urandom);
      if (loop_tog) loop_en = $urandom_range(0, 1) == 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R9: half-mode fall with no preceding half rise
    period(1'b1, '0, 1'b0, 1'b1, 10'h3FF, 1'b1, 1'b0, "R9");
    period(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1");
    // R2 R3 R4: full words back to back, falls ignored
    period(1'b0, 10'h2A5, 1'b1, 1'b1, 10'h3FF, 1'b0, 1'b0, "R3");
    period(1'b0, 10'h3C1, 1'b1, 1'b1, 10'h155, 1'b0, 1'b0, "R4");
    period(1'b0, 10'h001, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R2");
    period(1'b0, 10'h200, 1'b1, 1'b1, 10'h0FF, 1'b0, 1'b0, "R9");
    for (int j = 0; j < 6; j++)
      period(1'b0, W'($urandom), 1'b1, 1'b1, W'($urandom), 1'b0, 1'b0, "R4");
    // R8: no new words, tail must go low
    period(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R8");
    period(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R8");
    // R5: split words, upper bus bits randomised
    period(1'b1, 10'h3E0 | 10'h013, 1'b1, 1'b1, 10'h3E0 | 10'h00C, 1'b1, 1'b0, "R5");
    period(1'b1, 10'h01F, 1'b1, 1'b1, 10'h000, 1'b1, 1'b0, "R5");
    for (int j = 0; j < 6; j++)
      period(1'b1, W'($urandom), 1'b1, 1'b1, W'($urandom), 1'b1, 1'b0, "R5");
    // R6: mode flips between the rise and the fall
    period(1'b1, 10'h015, 1'b1, 1'b1, 10'h00A, 1'b0, 1'b0, "R6");
    period(1'b0, 10'h155, 1'b1, 1'b1, 10'h01F, 1'b1, 1'b0, "R6");
    for (int j = 0; j < 6; j++)
      period(j[0], W'($urandom), 1'b1, 1'b1, W'($urandom), !j[0], 1'b0, "R6");
    // R7: loopback toggled inside words
    for (int j = 0; j < 6; j++)
      period(j[1], W'($urandom), 1'b1, 1'b1, W'($urandom), j[1], 1'b1, "R7");
    loop_en = 1'b0;
    period(1'b0, 10'h3FF, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R7");
    period(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R8");
    // R1: reset again mid-word, line must idle low
    cur_tag = "R1";
    period(1'b0, 10'h3FF, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R2");
    cur_tag = "R1";
    tick(); rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (6) tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule